// File: doc/BRIEF.md
# Asynchronous Strobe and Bus Capture Synchronizer

This block takes a strobe that is not related to the system clock, together with a data bus that the strobe qualifies, and brings both into the system clock domain. It provides three registered outputs. The first is a clean synchronized copy of the strobe level. The second is a one-cycle enable pulse on each leading edge of that synchronized level. The third is a copy of the bus taken on the cycle that follows the pulse. The raw strobe enters exactly one flip-flop. Only its synchronized form is used by the rest of the logic.

A parameter picks one of two front ends. The long-pulse front end is meant for strobes that stay high for at least one system clock period. It passes the strobe through a chain of system-clock flip-flops. The short-pulse front end is meant for strobes that may be narrower than one clock period. Its first flip-flop is clocked by the strobe itself and has its data input tied high, so any rising edge sets it. The last stage of the system-clock chain then clears that flip-flop asynchronously, which re-arms it for the next strobe.

The sender must hold the bus stable from the strobe's leading edge until the capture cycle. That cycle comes four system clock edges after the edge. In short-pulse mode, leading edges must be at least five clocks apart. The block assumes both rules and does not check either of them.

Top module: `strobe_capture_sync`

## Requirements
- R1: While the synchronous reset `rst` is high, each clock edge clears `strobe_sync`, `fire_pulse` and `bus_held` to zero.
- R2: In long-pulse mode, a strobe that rises between two clock edges shows on `strobe_sync` after the second edge that follows. It then stays high for as many cycles as the strobe was sampled high.
- R3: `fire_pulse` goes high on the cycle after `strobe_sync` rises. It stays high for exactly one cycle.
- R4: On the edge after `fire_pulse` is high, `bus_held` loads the value that `bus_async` had at that edge.
- R5: When `fire_pulse` is low, `bus_held` keeps its value, whatever `bus_async` does.
- R6: In short-pulse mode, a strobe pulse narrower than one clock period yields exactly one `fire_pulse`. `strobe_sync` rises after the second clock edge that follows the pulse.
- R7: In short-pulse mode, the last synchronizer stage clears the capture flop. As a result, `strobe_sync` is high for exactly two cycles per pulse, whatever the pulse width. Each later pulse produces its own `fire_pulse`.
- R8: A strobe held high for many cycles produces only one `fire_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_async | input | 1 | Asynchronous strobe qualifying the bus |
| bus_async | input | DATA_W | Bus sampled when the strobe is seen |
| strobe_sync | output | 1 | Synchronized strobe level |
| fire_pulse | output | 1 | One-cycle enable on each leading edge |
| bus_held | output | DATA_W | Registered bus copy |

## Verification
A long-pulse instance is driven with strobes whose widths sweep from one to six clocks. Each strobe carries a different bus value. Comparing widths separates a correct level path from one with the wrong stage count. The longest widths show whether a held strobe retriggers the one-shot. A short-pulse instance receives sub-nanosecond and half-period pulses, and also a pulse several clocks long. Every pulse must give one enable, a synchronized high lasting two cycles, and the right captured value. The bus is changed after each capture to show that the held copy does not follow the bus.

// File: rtl/strobe_sync_pkg.sv
`timescale 1ns/1ps
package strobe_sync_pkg;
  typedef enum logic {MODE_LONG = 1'b0, MODE_SHORT = 1'b1} pulse_mode_e;
endpackage

// File: rtl/sync_front.sv
`timescale 1ns/1ps
module sync_front
  import strobe_sync_pkg::*;
#(
  parameter pulse_mode_e MODE   = MODE_LONG,
  parameter int          STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_async,
  output logic level
);
  localparam int LAST = STAGES - 1;

  logic              first_in;
  logic [STAGES-1:0] chain_q;

  generate
    if (MODE == MODE_SHORT) begin : g_short
      logic catch_q;
      logic clr;
      // The last stage re-arms the edge catcher once the event is seen.
      assign clr = chain_q[LAST] | rst;
      always_ff @(posedge strobe_async or posedge clr) begin
        if (clr) catch_q <= 1'b0;
        else     catch_q <= 1'b1;
      end
      assign first_in = catch_q;

      // R7: the catcher is already cleared whenever the last stage is high
      assert_catch_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        chain_q[LAST] |-> !catch_q);
    end else begin : g_long
      assign first_in = strobe_async;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], first_in};
  end

  assign level = chain_q[LAST];

  // R2: each stage hands its value to the next one cycle later
  assert_chain_shift_R2: assert property (@(posedge clk) disable iff (rst)
    chain_q[0] |=> chain_q[1]);
endmodule

// File: rtl/edge_oneshot.sv
`timescale 1ns/1ps
module edge_oneshot (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic fire
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      fire   <= 1'b0;
    end else begin
      prev_q <= level;
      fire   <= level & ~prev_q;
    end
  end

  assert_fire_single_R3: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
  assert_fire_follows_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(level) |=> fire);
  assert_fire_needs_level_R8: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(level));
endmodule

// File: rtl/bus_latch.sv
`timescale 1ns/1ps
module bus_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    en |=> (q == $past(d)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
endmodule

// File: rtl/strobe_capture_sync.sv
`timescale 1ns/1ps
module strobe_capture_sync
  import strobe_sync_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter pulse_mode_e MODE   = MODE_LONG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_async,
  input  logic [DATA_W-1:0] bus_async,
  output logic              strobe_sync,
  output logic              fire_pulse,
  output logic [DATA_W-1:0] bus_held
);
  localparam int SYNC_STAGES = 2;

  sync_front #(.MODE(MODE), .STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .strobe_async(strobe_async), .level(strobe_sync)
  );

  edge_oneshot u_edge (
    .clk(clk), .rst(rst), .level(strobe_sync), .fire(fire_pulse)
  );

  bus_latch #(.WIDTH(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .en(fire_pulse), .d(bus_async), .q(bus_held)
  );

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!strobe_sync && !fire_pulse && bus_held == '0));
endmodule

// File: tb/strobe_capture_sync_test.sv
`timescale 1ns/1ps
module strobe_capture_sync_test;
  import strobe_sync_pkg::*;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         stb_l = 1'b0;
  logic         stb_s = 1'b0;
  logic [W-1:0] bus = '0;
  logic         lvl_l, fire_l, lvl_s, fire_s;
  logic [W-1:0] held_l, held_s;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  strobe_capture_sync #(.DATA_W(W), .MODE(MODE_LONG)) uut (
    .clk(clk), .rst(rst), .strobe_async(stb_l), .bus_async(bus),
    .strobe_sync(lvl_l), .fire_pulse(fire_l), .bus_held(held_l));

  strobe_capture_sync #(.DATA_W(W), .MODE(MODE_SHORT)) uut_short (
    .clk(clk), .rst(rst), .strobe_async(stb_s), .bus_async(bus),
    .strobe_sync(lvl_s), .fire_pulse(fire_s), .bus_held(held_s));

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // short=0: strobe high for width_clk cycles on the long instance.
  // short=1: width_ps picoseconds on the short instance (0 means use width_clk).
  task automatic trial(input bit short, input int width_clk, input int width_ps,
                       input logic [W-1:0] val);
    int fires = 0, first_fire = -1, first_lvl = -1, lvl_cycles = 0;
    logic lv, fi;
    @(posedge clk);
    #1;
    bus = val;
    if (short) stb_s = 1'b1; else stb_l = 1'b1;
    if (short && width_ps > 0) begin
      #(width_ps * 1ps);
      stb_s = 1'b0;
    end
    for (int c = 1; c <= 12; c++) begin
      @(posedge clk);
      #1;
      if (c == width_clk) begin
        if (short) stb_s = 1'b0; else stb_l = 1'b0;
      end
      if (c == 5) bus = ~val;
      @(negedge clk);
      lv = short ? lvl_s : lvl_l;
      fi = short ? fire_s : fire_l;
      if (lv) begin
        lvl_cycles++;
        if (first_lvl < 0) first_lvl = c;
      end
      if (fi) begin
        fires++;
        if (first_fire < 0) first_fire = c;
      end
    end
    if (short) begin
      check("R6 first sync cycle", first_lvl, 2);
      check("R6 one fire per narrow pulse", fires, 1);
      check("R7 sync high cycles", lvl_cycles, 2);
      check("R4 captured bus", int'(held_s), int'(val));
      check("R5 held after bus change", int'(held_s), int'(val));
    end else begin
      check("R2 first sync cycle", first_lvl, 2);
      check("R2 sync high cycles", lvl_cycles, width_clk);
      check("R3 fire cycle", first_fire, 3);
      check("R8 one fire per pulse", fires, 1);
      check("R4 captured bus", int'(held_l), int'(val));
      check("R5 held after bus change", int'(held_l), int'(val));
    end
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset sync long", int'(lvl_l), 0);
    check("R1 reset fire long", int'(fire_l), 0);
    check("R1 reset bus long", int'(held_l), 0);
    check("R1 reset sync short", int'(lvl_s), 0);
    check("R1 reset bus short", int'(held_s), 0);
    rst = 1'b0;
    repeat (2) @(posedge clk);

    for (int w = 1; w <= 6; w++) trial(1'b0, w, 0, W'(8'h11 * w + 8'h03));
    trial(1'b1, 12, 300, 8'hA5);
    trial(1'b1, 12, 900, 8'h5A);
    trial(1'b1, 12, 1500, 8'hC3);
    trial(1'b1, 4, 0, 8'h3C);
    trial(1'b1, 12, 200, 8'hFF);

    // Bus wiggle with no strobe leaves the held value alone (R5)
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      #1 bus = W'(k * 37);
    end
    @(negedge clk);
    check("R5 no strobe long", int'(held_l), int'(8'h11 * 6 + 8'h03));
    check("R5 no strobe short", int'(held_s), int'(8'hFF));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule